// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Controller

This block is the device side of a three-wire serial memory of 256 bytes. A host drives a select line, a serial clock and a data-in line. The block answers on one data-out line with its own output enable. All three inputs are sampled by a faster system clock and pass through a synchroniser. Serial clock rising edges are found from the synchronised copy. An instruction begins with a start bit. Next come a two-bit opcode and a nine-bit field, which is one spare bit and then an eight-bit address. Write-type instructions then carry eight data bits.

The block can read a byte and keep streaming the following bytes, write one byte, erase one byte, erase the whole array, or fill the whole array with one value. Two further instructions lock and unlock programming. After reset the block is locked. Programming runs for a fixed number of system clocks, set by a parameter for each kind. While a cycle runs, the host can drop and raise the select line to watch a busy/ready flag on data-out. The storage is a register array that resets to all ones.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset, sdo_oe_o is 0, programming is locked, and every one of the 256 locations reads 0xFF.
- R2: A start is taken at the first serial clock rising edge where select and data-in are both 1. Edges with data-in at 0 before that change nothing.
- R3: The two bits after the start are the opcode, MSB first: 10 read, 01 write, 11 erase one byte. With opcode 00, the two top bits of the nine-bit field pick the instruction: 00 lock, 01 fill all, 10 erase all, 11 unlock. The address is the low eight bits of the field, MSB first.
- R4: On a read, the 12th rising edge drives sdo_o to 0 with sdo_oe_o at 1. The next 8 edges present the addressed byte MSB first.
- R5: While select stays high during a read, further edges stream the following addresses with no extra zero bit. The address wraps from 0xFF to 0x00.
- R6: While locked, write, erase, erase-all and fill-all change no location and start no busy cycle. Unlock stays in force until lock. Read works in both states.
- R7: A write of 20 clocks stores its data byte at the address once the programming cycle ends.
- R8: Erase sets the addressed byte to 0xFF, and erase-all sets all bytes to 0xFF. Both start at the 12th edge.
- R9: Fill-all, after its 20th edge, leaves every location equal to the data byte.
- R10: If select falls and rises again during a cycle, sdo_oe_o is 1 and sdo_o is 0 while busy, then 1 when ready. The cycle lasts T_WORD, T_ERAL or T_WRAL system clocks.
- R11: A start or instruction clocked in while busy is ignored. Only the status output responds.
- R12: Select low aborts any partial instruction and turns sdo_oe_o off.
- R13: After an instruction completes, edges with data-in at 0 are ignored. A new start under the same select begins a new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Serial select, active high |
| sclk_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out (read data or busy/ready flag) |
| sdo_oe_o | output | 1 | Output enable for sdo_o |

## Verification
The assertions check on every cycle that no programming starts while locked or while busy, and that a busy cycle does not end before its counter reaches zero. They also check that a commit always has a latched request, that the output enable goes off after deselect, and that serial edges arriving while busy leave the decoder idle. Only the bench scenarios can show the bit order and the dummy zero on reads, the wrap of sequential reads, and the stored values after each programming kind. The same holds for the lengths of the busy windows and for an aborted instruction leaving memory unchanged.

// File: rtl/mw_pkg.sv
package mw_pkg;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int FIELD_W = ADDR_W + 1;
    localparam int HDR_W   = 2 + FIELD_W;
    localparam int CNT_W   = $clog2(HDR_W);
    localparam int IDX_W   = $clog2(DATA_W);

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        EX_LOCK   = 2'b00,
        EX_FILL   = 2'b01,
        EX_CLEAR  = 2'b10,
        EX_UNLOCK = 2'b11
    } ext_e;

    typedef enum logic [2:0] {
        PG_NONE, PG_WORD, PG_ERASE, PG_CLEAR_ALL, PG_FILL_ALL
    } prog_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_HDR, ST_DATA, ST_READ
    } state_e;

    typedef struct packed {
        prog_e               kind;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
    } prog_req_t;

    function automatic op_e hdr_op(input logic [HDR_W-1:0] h);
        return op_e'(h[HDR_W-1 -: 2]);
    endfunction

    function automatic ext_e hdr_ext(input logic [HDR_W-1:0] h);
        return ext_e'(h[FIELD_W-1 -: 2]);
    endfunction

    function automatic logic [ADDR_W-1:0] hdr_addr(input logic [HDR_W-1:0] h);
        return h[ADDR_W-1:0];
    endfunction
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic cs_o,
    output logic sdi_o,
    output logic rise_o,
    output logic cs_rise_o
);
    logic [STAGES-1:0] cs_p, ck_p, di_p;
    logic ck_d, cs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_p <= '0;
            ck_p <= '0;
            di_p <= '0;
            ck_d <= 1'b0;
            cs_d <= 1'b0;
        end else begin
            cs_p <= {cs_p[STAGES-2:0], cs_i};
            ck_p <= {ck_p[STAGES-2:0], sclk_i};
            di_p <= {di_p[STAGES-2:0], sdi_i};
            ck_d <= ck_p[STAGES-1];
            cs_d <= cs_p[STAGES-1];
        end
    end

    assign cs_o      = cs_p[STAGES-1];
    assign sdi_o     = di_p[STAGES-1];
    assign rise_o    = ck_p[STAGES-1] & ~ck_d;
    assign cs_rise_o = cs_p[STAGES-1] & ~cs_d;
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer
    import mw_pkg::*;
#(
    parameter int T_WORD = 40,
    parameter int T_ERAL = 60,
    parameter int T_WRAL = 80
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  go_i,
    input  prog_e kind_i,
    output logic  busy_o,
    output logic  done_o
);
    localparam int T_MAX = (T_WORD > T_ERAL) ? ((T_WORD > T_WRAL) ? T_WORD : T_WRAL)
                                             : ((T_ERAL > T_WRAL) ? T_ERAL : T_WRAL);
    localparam int CW = $clog2(T_MAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] len_m1;

    always_comb begin
        unique case (kind_i)
            PG_CLEAR_ALL: len_m1 = CW'(T_ERAL - 1);
            PG_FILL_ALL:  len_m1 = CW'(T_WRAL - 1);
            default:      len_m1 = CW'(T_WORD - 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (go_i && !busy_o) begin
                busy_o <= 1'b1;
                cnt    <= len_m1;
            end else if (busy_o) begin
                if (cnt == '0) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    AST_GO_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        go_i |-> !busy_o); // R11
    AST_BUSY_RUNS_OUT: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cnt != '0) |=> busy_o); // R10
endmodule

// File: rtl/mw_mem_array.sv
module mw_mem_array
    import mw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go_i,
    input  prog_req_t         req_i,
    input  logic              commit_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] cells [DEPTH];
    prog_req_t         pend;
    logic              pend_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
            pend   <= '0;
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else begin
            if (go_i) begin
                pend   <= req_i;
                pend_v <= 1'b1;
            end
            if (commit_i) begin
                pend_v <= 1'b0;
                unique case (pend.kind)
                    PG_WORD:      cells[pend.addr] <= pend.data;
                    PG_ERASE:     cells[pend.addr] <= '1;
                    PG_CLEAR_ALL: for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
                    PG_FILL_ALL:  for (int i = 0; i < DEPTH; i++) cells[i] <= pend.data;
                    default:      ;
                endcase
            end
        end
    end

    assign rd_data_o = cells[rd_addr_i];

    AST_COMMIT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        commit_i |-> pend_v); // R7
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
    import mw_pkg::*;
#(
    parameter int T_WORD      = 40,
    parameter int T_ERAL      = 60,
    parameter int T_WRAL      = 80,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic sdo_o,
    output logic sdo_oe_o
);
    logic cs_s, di_s, ck_rise, cs_rise;
    logic busy, done, go;
    prog_req_t req;

    state_e            st;
    logic [CNT_W-1:0]  cnt;
    logic [HDR_W-1:0]  hdr;
    logic [DATA_W-1:0] dsr;
    logic              wen, rd_on, stat_on, sdo_q;
    logic [ADDR_W-1:0] rd_addr;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_data;

    logic [HDR_W-1:0]  hdr_nx;
    logic [DATA_W-1:0] dsr_nx;
    assign hdr_nx = {hdr[HDR_W-2:0], di_s};
    assign dsr_nx = {dsr[DATA_W-2:0], di_s};

    mw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .cs_i(sel_i), .sclk_i(sclk_i), .sdi_i(sdi_i),
        .cs_o(cs_s), .sdi_o(di_s), .rise_o(ck_rise), .cs_rise_o(cs_rise)
    );

    mw_prog_timer #(.T_WORD(T_WORD), .T_ERAL(T_ERAL), .T_WRAL(T_WRAL)) u_timer (
        .clk(clk), .rst(rst), .go_i(go), .kind_i(req.kind),
        .busy_o(busy), .done_o(done)
    );

    mw_mem_array u_mem (
        .clk(clk), .rst(rst), .go_i(go), .req_i(req), .commit_i(done),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            hdr     <= '0;
            dsr     <= '0;
            wen     <= 1'b0;
            rd_on   <= 1'b0;
            stat_on <= 1'b0;
            sdo_q   <= 1'b0;
            rd_addr <= '0;
            rd_idx  <= '0;
            go      <= 1'b0;
            req     <= '0;
        end else begin
            go <= 1'b0;
            if (!cs_s) begin
                st      <= ST_IDLE;
                cnt     <= '0;
                rd_on   <= 1'b0;
                stat_on <= 1'b0;
            end else begin
                if (cs_rise && busy) stat_on <= 1'b1;
                if (ck_rise) begin
                    unique case (st)
                        ST_IDLE: if (di_s && !busy) begin
                            st      <= ST_HDR;
                            cnt     <= '0;
                            stat_on <= 1'b0;
                        end
                        ST_HDR: begin
                            hdr <= hdr_nx;
                            cnt <= cnt + 1'b1;
                            if (cnt == CNT_W'(HDR_W - 1)) begin
                                cnt <= '0;
                                st  <= ST_IDLE;
                                unique case (hdr_op(hdr_nx))
                                    OP_READ: begin
                                        st      <= ST_READ;
                                        rd_on   <= 1'b1;
                                        sdo_q   <= 1'b0;
                                        rd_addr <= hdr_addr(hdr_nx);
                                        rd_idx  <= '0;
                                    end
                                    OP_WRITE: st <= ST_DATA;
                                    OP_ERASE: if (wen) begin
                                        go       <= 1'b1;
                                        req.kind <= PG_ERASE;
                                        req.addr <= hdr_addr(hdr_nx);
                                        req.data <= '1;
                                    end
                                    default: begin
                                        unique case (hdr_ext(hdr_nx))
                                            EX_LOCK:   wen <= 1'b0;
                                            EX_UNLOCK: wen <= 1'b1;
                                            EX_FILL:   st  <= ST_DATA;
                                            default: if (wen) begin
                                                go       <= 1'b1;
                                                req.kind <= PG_CLEAR_ALL;
                                                req.addr <= '0;
                                                req.data <= '1;
                                            end
                                        endcase
                                    end
                                endcase
                            end
                        end
                        ST_DATA: begin
                            dsr <= dsr_nx;
                            cnt <= cnt + 1'b1;
                            if (cnt == CNT_W'(DATA_W - 1)) begin
                                cnt <= '0;
                                st  <= ST_IDLE;
                                if (wen) begin
                                    go       <= 1'b1;
                                    req.kind <= (hdr_op(hdr) == OP_WRITE) ? PG_WORD : PG_FILL_ALL;
                                    req.addr <= hdr_addr(hdr);
                                    req.data <= dsr_nx;
                                end
                            end
                        end
                        default: begin
                            sdo_q  <= rd_data[IDX_W'(DATA_W - 1) - rd_idx];
                            rd_idx <= rd_idx + IDX_W'(1);
                            if (rd_idx == IDX_W'(DATA_W - 1)) begin
                                rd_idx  <= '0;
                                rd_addr <= rd_addr + 1'b1;
                            end
                        end
                    endcase
                end
            end
        end
    end

    assign sdo_o    = stat_on ? ~busy : sdo_q;
    assign sdo_oe_o = rd_on | stat_on;

    AST_NO_PROG_WHEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
        go |-> wen); // R6
    AST_QUIET_AFTER_DESELECT: assert property (@(posedge clk) disable iff (rst)
        !cs_s |=> !sdo_oe_o); // R12
    AST_BUSY_EDGES_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && ck_rise && st == ST_IDLE) |=> st == ST_IDLE); // R11
endmodule

// File: tb/mw_eeprom_slave_bench.sv
module mw_eeprom_slave_bench;
    localparam int TW = 200;
    localparam int TE = 300;
    localparam int TF = 400;
    localparam int H  = 4;

    logic clk = 1'b0;
    logic rst, sel, sclk, sdi;
    logic sdo, sdo_oe;
    logic last_q, last_oe;
    logic [7:0] exp_mem [256];
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mw_eeprom_slave #(.T_WORD(TW), .T_ERAL(TE), .T_WRAL(TF)) u_mw_eeprom_slave (
        .clk(clk), .rst(rst), .sel_i(sel), .sclk_i(sclk), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sbit(input logic b);
        sdi = b; tick(H);
        sclk = 1'b1; tick(H);
        last_q = sdo; last_oe = sdo_oe;
        sclk = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) sbit(v[i]);
    endtask

    task automatic select();
        sel = 1'b1; tick(6);
    endtask

    task automatic deselect();
        sel = 1'b0; sclk = 1'b0; sdi = 1'b0; tick(8);
    endtask

    function automatic logic [11:0] hdr(input logic [1:0] op, input logic [8:0] f);
        return {1'b1, op, f};
    endfunction

    task automatic read_bytes(input logic [7:0] a, input int n, input string tag);
        logic [7:0] b;
        for (int k = 0; k < n; k++) begin
            b = '0;
            for (int i = 0; i < 8; i++) begin
                sbit(1'b0);
                b = {b[6:0], last_q};
            end
            chk(tag, b, exp_mem[8'(a + k)]);
        end
    endtask

    task automatic read_check(input logic [7:0] a, input int n, input string tag);
        select();
        send(32'(hdr(2'b10, {1'b0, a})), 12);
        chk({tag, " R4 dummy zero"}, {last_oe, last_q}, 2'b10);
        read_bytes(a, n, tag);
        deselect();
    endtask

    // issue a programming command, then poll status through a fresh select
    task automatic do_prog(input logic [31:0] v, input int n, input bit busy_exp,
                           input int t, input string tag);
        int waited;
        select(); send(v, n); deselect();
        select();
        if (!busy_exp) begin
            chk({tag, " R6 no busy cycle"}, sdo_oe, 1'b0);
        end else begin
            chk({tag, " R10 busy shows 0"}, {sdo_oe, sdo}, 2'b10);
            waited = 0;
            while (sdo !== 1'b1 && waited < 3000) begin tick(1); waited++; end
            chk({tag, " R10 ready shows 1"}, {sdo_oe, sdo}, 2'b11);
            chk({tag, " R10 duration window"}, (waited > t - 60 && waited < t) ? 1 : 0, 1);
        end
        deselect();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] a, d;
        sel = 0; sclk = 0; sdi = 0; rst = 1;
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
        tick(5); rst = 0; tick(3);
        chk("R1 oe after reset", sdo_oe, 1'b0);
        read_check(8'h00, 256, "R1 R5 full read after reset");

        // locked: write and erase-all ignored
        do_prog(32'({hdr(2'b01, 9'h003), 8'h3C}), 20, 0, TW, "R6 write locked");
        do_prog(32'(hdr(2'b00, 9'h100)), 12, 0, TE, "R6 erase-all locked");
        read_check(8'h03, 1, "R6 read while locked");

        // R2 R13: idle clocks, unlock, idle clocks, read in same select
        select();
        send(0, 5);
        send(32'(hdr(2'b00, 9'h180)), 12);
        chk("R3 unlock leaves DO off", sdo_oe, 1'b0);
        send(0, 3);
        chk("R13 idle clocks keep DO off", sdo_oe, 1'b0);
        send(32'(hdr(2'b10, 9'h003)), 12);
        chk("R13 R2 second start dummy", {last_oe, last_q}, 2'b10);
        read_bytes(8'h03, 1, "R13 read after unlock");
        deselect();

        // R7 write sweep
        for (int k = 0; k < 16; k++) begin
            a = 8'(k * 17);
            d = 8'(k * 37 + 5);
            do_prog(32'({hdr(2'b01, {1'b0, a}), d}), 20, 1, TW, "R7 write");
            exp_mem[a] = d;
        end
        for (int k = 0; k < 16; k++) read_check(8'(k * 17), 1, "R7 readback");
        read_check(8'hFE, 4, "R5 wrap read");

        // R11: a command clocked during busy is ignored
        select(); send(32'({hdr(2'b01, 9'h040), 8'h99}), 20); deselect();
        exp_mem[8'h40] = 8'h99;
        select();
        for (int i = 0; i < 12; i++) begin
            sbit(hdr(2'b11, 9'h040) >> (11 - i) & 12'h1 ? 1'b1 : 1'b0);
            chk("R11 status during ignored erase", {last_oe, last_q}, 2'b10);
        end
        while (sdo !== 1'b1) tick(1);
        deselect();
        read_check(8'h40, 1, "R11 erase ignored while busy");

        // R8 single erase
        do_prog(32'(hdr(2'b11, 9'h011)), 12, 1, TW, "R8 erase");
        exp_mem[8'h11] = 8'hFF;
        read_check(8'h10, 3, "R8 erase readback");

        // R6 relock
        do_prog(32'(hdr(2'b00, 9'h000)), 12, 0, TW, "R6 lock cmd");
        do_prog(32'({hdr(2'b01, 9'h022), 8'h00}), 20, 0, TW, "R6 write after lock");
        read_check(8'h22, 1, "R6 relocked readback");
        do_prog(32'(hdr(2'b00, 9'h180)), 12, 0, TW, "R6 unlock cmd");

        // R9 fill all
        do_prog(32'({hdr(2'b00, 9'h080), 8'h5A}), 20, 1, TF, "R9 fill-all");
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'h5A;
        read_check(8'h00, 256, "R9 fill readback");

        // R12 aborted write
        select(); send(32'({hdr(2'b01, 9'h022), 8'h00}) >> 5, 15);
        sel = 1'b0; tick(6);
        chk("R12 DO off after deselect", sdo_oe, 1'b0);
        deselect();
        read_check(8'h22, 1, "R12 aborted write");

        // R8 erase all
        do_prog(32'(hdr(2'b00, 9'h100)), 12, 1, TE, "R8 erase-all");
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
        read_check(8'h00, 256, "R8 erase-all readback");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule